// File: doc/BRIEF.md
# Vector Operand Fetch and Swizzle Stage

This block is the operand-read and destination-decode stage of a four-lane vector shader pipeline. Each lane holds a 24-bit float: 1 sign bit, 7 exponent bits and 16 mantissa bits. For every issued instruction the block turns the two 7-bit source indices into a register-file kind and a local index. Neighbouring register files answer on the same cycle. The block then reorders the four returned components of each source and can negate them. It also decodes the destination index into an output slot, a temporary slot or a discard.

The first source may be displaced by one of two signed address registers before it is decoded. Component reordering, negation and the destination write mask all come from an operand descriptor word. A neighbouring table, indexed by the instruction's descriptor field, supplies that word. An instruction flagged as having swapped source roles is not executed: the stage reports an unsupported-instruction error in its place. Results appear on registered outputs one clock after issue.

Top module: `vec_operand_fetch`

## Requirements
- R1: A source index below 0x10 reads the input file (kind 1, local index = index). An index from 0x10 to 0x1F reads the temporary file (kind 2, local index = index - 0x10). An index from 0x20 to 0x7F reads the uniform file (kind 3, local index = index - 0x20).
- R2: A first-source index that falls outside 0 to 0x7F after the offset is added reads kind 0. The operand value for kind 0 is all-zero lanes, whatever the read data is; negation still applies to it.
- R3: Address selector 1 adds signed address register 0 to the first source index before decoding, and selector 2 adds address register 1. Selectors 0 and 3 add nothing. The second source is never offset.
- R4: Lane i of each operand is the fetched component numbered by a 2-bit selector (0=x, 1=y, 2=z, 3=w). Lane i is held in data bits [24i+23:24i]. The source-1 selector for lane i sits at descriptor bits [5+2i:4+2i], and the source-2 selector at bits [14+2i:13+2i].
- R5: Descriptor bit 12 negates source 1 and bit 21 negates source 2. Negation inverts bit 23 of every lane of that operand and leaves all other bits unchanged.
- R6: The write mask output equals descriptor bits [3:0], with bit i enabling lane i.
- R7: A destination index below 0x08 gives kind 1 and slot = index. An index from 0x10 to 0x1F gives kind 2 and slot = index - 0x10. Every other index gives kind 0 (discard) with slot 0.
- R8: A valid instruction with the swapped-roles flag set raises out_err for one cycle and does not raise out_valid.
- R9: Outputs are registered, with one cycle of latency from issue. Reset clears all outputs to zero, and an idle cycle produces neither out_valid nor out_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction issue strobe |
| in_inverted | input | 1 | Instruction uses swapped source roles |
| in_src1 | input | 7 | First source register index |
| in_src2 | input | 7 | Second source register index |
| in_dst | input | 7 | Destination register index |
| in_asel | input | 2 | Address register selector for the first source |
| in_areg0 | input | 8 | Signed address register 0 |
| in_areg1 | input | 8 | Signed address register 1 |
| in_desc | input | 22 | Operand descriptor word |
| rd1_kind | output | 2 | File read by source 1 (0 none, 1 input, 2 temp, 3 uniform) |
| rd1_idx | output | 7 | Local index within that file |
| rd1_data | input | 96 | Four components returned for source 1 |
| rd2_kind | output | 2 | File read by source 2 |
| rd2_idx | output | 7 | Local index for source 2 |
| rd2_data | input | 96 | Four components returned for source 2 |
| out_valid | output | 1 | Operands ready |
| out_err | output | 1 | Unsupported instruction |
| out_op1 | output | 96 | Reordered, optionally negated source 1 |
| out_op2 | output | 96 | Reordered, optionally negated source 2 |
| out_mask | output | 4 | Destination lane write enables |
| out_dst_kind | output | 2 | Destination kind (0 discard, 1 output, 2 temp) |
| out_dst_idx | output | 4 | Destination slot |

## Verification
A wrong file decode or a wrong offset sum shows up one clock after issue as an operand whose lanes carry another register's signature. A dropped dummy shows up the same way: non-zero magnitudes appear where only sign bits may be set. A bad selector or negate field corrupts individual lanes or single bit-23 positions in that same cycle. A misdecoded destination or a mishandled swapped-roles flag is visible immediately in the destination fields or in the valid and error strobes.

// File: rtl/vec_operand_fetch.sv
module vec_operand_fetch #(
  parameter int LANES   = 4,
  parameter int FW      = 24,
  parameter int IDXW    = 7,
  parameter int AREGW   = 8,
  parameter int NUM_IN  = 16,
  parameter int NUM_TMP = 16,
  parameter int NUM_UNI = 96,
  parameter int NUM_OUT = 8,
  localparam int SELW   = $clog2(LANES),
  localparam int VW     = LANES * FW,
  localparam int DESCW  = LANES + 2 * (LANES * SELW + 1),
  localparam int LIDXW  = $clog2(NUM_UNI),
  localparam int DIDXW  = $clog2(NUM_TMP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_inverted,
  input  logic [IDXW-1:0]  in_src1,
  input  logic [IDXW-1:0]  in_src2,
  input  logic [IDXW-1:0]  in_dst,
  input  logic [1:0]       in_asel,
  input  logic [AREGW-1:0] in_areg0,
  input  logic [AREGW-1:0] in_areg1,
  input  logic [DESCW-1:0] in_desc,
  output logic [1:0]       rd1_kind,
  output logic [LIDXW-1:0] rd1_idx,
  input  logic [VW-1:0]    rd1_data,
  output logic [1:0]       rd2_kind,
  output logic [LIDXW-1:0] rd2_idx,
  input  logic [VW-1:0]    rd2_data,
  output logic             out_valid,
  output logic             out_err,
  output logic [VW-1:0]    out_op1,
  output logic [VW-1:0]    out_op2,
  output logic [LANES-1:0] out_mask,
  output logic [1:0]       out_dst_kind,
  output logic [DIDXW-1:0] out_dst_idx
);
  localparam int SW       = ((IDXW > AREGW) ? IDXW : AREGW) + 2;
  localparam int NEG1_BIT = LANES + LANES * SELW;
  localparam int SEL2_LO  = NEG1_BIT + 1;
  localparam int NEG2_BIT = SEL2_LO + LANES * SELW;
  localparam logic signed [SW-1:0] S_TMP = SW'(NUM_IN);
  localparam logic signed [SW-1:0] S_UNI = SW'(NUM_IN + NUM_TMP);
  localparam logic signed [SW-1:0] S_END = SW'(NUM_IN + NUM_TMP + NUM_UNI);

  function automatic logic [LIDXW+1:0] decode_src(input logic signed [SW-1:0] x);
    if (x < 0)          return '0;
    else if (x < S_TMP) return {2'd1, LIDXW'(x)};
    else if (x < S_UNI) return {2'd2, LIDXW'(x - S_TMP)};
    else if (x < S_END) return {2'd3, LIDXW'(x - S_UNI)};
    else                return '0;
  endfunction

  logic signed [AREGW-1:0] aoff;
  logic signed [SW-1:0]    s1_eff, s2_eff;

  assign aoff   = (in_asel == 2'd1) ? in_areg0 : (in_asel == 2'd2) ? in_areg1 : '0;
  assign s1_eff = signed'(SW'({1'b0, in_src1})) + SW'(aoff);
  assign s2_eff = signed'(SW'({1'b0, in_src2}));

  assign {rd1_kind, rd1_idx} = decode_src(s1_eff);
  assign {rd2_kind, rd2_idx} = decode_src(s2_eff);

  logic [VW-1:0] d1, d2, sw1, sw2;
  assign d1 = (rd1_kind == 2'd0) ? '0 : rd1_data;
  assign d2 = (rd2_kind == 2'd0) ? '0 : rd2_data;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SELW-1:0] sel1, sel2;
    assign sel1 = in_desc[LANES + SELW*l +: SELW];
    assign sel2 = in_desc[SEL2_LO + SELW*l +: SELW];
    assign sw1[FW*l +: FW] = d1[FW*sel1 +: FW] ^ {in_desc[NEG1_BIT], {(FW-1){1'b0}}};
    assign sw2[FW*l +: FW] = d2[FW*sel2 +: FW] ^ {in_desc[NEG2_BIT], {(FW-1){1'b0}}};
  end

  logic [1:0]       dk;
  logic [DIDXW-1:0] di;
  always_comb begin
    dk = 2'd0;
    di = '0;
    if (int'(in_dst) < NUM_OUT) begin
      dk = 2'd1;
      di = DIDXW'(in_dst);
    end else if (int'(in_dst) >= NUM_IN && int'(in_dst) < NUM_IN + NUM_TMP) begin
      dk = 2'd2;
      di = DIDXW'(in_dst - IDXW'(NUM_IN));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_err      <= 1'b0;
      out_op1      <= '0;
      out_op2      <= '0;
      out_mask     <= '0;
      out_dst_kind <= '0;
      out_dst_idx  <= '0;
    end else begin
      out_valid    <= in_valid & ~in_inverted;
      out_err      <= in_valid & in_inverted;
      out_op1      <= sw1;
      out_op2      <= sw2;
      out_mask     <= in_desc[LANES-1:0];
      out_dst_kind <= dk;
      out_dst_idx  <= di;
    end
  end

  logic [VW-1:0] mag_mask;
  for (genvar l = 0; l < LANES; l++) begin : g_mag
    assign mag_mask[FW*l +: FW] = {1'b0, {(FW-1){1'b1}}};
  end

  // R1
  uni_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd1_kind == 2'd3) |-> int'(rd1_idx) < NUM_UNI);

  // R3
  same_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_asel == 2'd0 && in_src1 == in_src2) |-> (rd1_kind == rd2_kind && rd1_idx == rd2_idx));

  // R2
  dummy_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rd1_kind == 2'd0) |=> ((out_op1 & mag_mask) == '0));

  // R7
  dst_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_dst_kind != 2'd3 && (out_dst_kind != 2'd0 || out_dst_idx == '0));

  // R8
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_err));

  // R9
  issue_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || out_err) |-> $past(in_valid));
endmodule

// File: tb/vec_operand_fetch_test.sv
module vec_operand_fetch_test;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_inverted = 1'b0;
  logic [6:0]  in_src1 = '0, in_src2 = '0, in_dst = '0;
  logic [1:0]  in_asel = '0;
  logic [7:0]  in_areg0 = '0, in_areg1 = '0;
  logic [21:0] in_desc = '0;
  logic [1:0]  rd1_kind, rd2_kind;
  logic [6:0]  rd1_idx, rd2_idx;
  logic [95:0] rd1_data, rd2_data;
  logic        out_valid, out_err;
  logic [95:0] out_op1, out_op2;
  logic [3:0]  out_mask;
  logic [1:0]  out_dst_kind;
  logic [3:0]  out_dst_idx;

  vec_operand_fetch uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_inverted(in_inverted),
    .in_src1(in_src1), .in_src2(in_src2), .in_dst(in_dst), .in_asel(in_asel),
    .in_areg0(in_areg0), .in_areg1(in_areg1), .in_desc(in_desc),
    .rd1_kind(rd1_kind), .rd1_idx(rd1_idx), .rd1_data(rd1_data),
    .rd2_kind(rd2_kind), .rd2_idx(rd2_idx), .rd2_data(rd2_data),
    .out_valid(out_valid), .out_err(out_err), .out_op1(out_op1), .out_op2(out_op2),
    .out_mask(out_mask), .out_dst_kind(out_dst_kind), .out_dst_idx(out_dst_idx));

  int checks = 0, failures = 0, cyc = 0;
  bit done = 1'b0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [95:0] filevec(int base, int i);
    logic [95:0] v;
    for (int j = 0; j < 4; j++) v[24*j +: 24] = 24'(base | (i << 4) | j);
    return v;
  endfunction

  // register file model answering the block's read requests
  function automatic logic [95:0] mem_read(logic [1:0] k, logic [6:0] i);
    if (k == 2'd1 && i < 16) return filevec(24'h100000, int'(i));
    if (k == 2'd2 && i < 16) return filevec(24'h200000, int'(i));
    if (k == 2'd3 && i < 96) return filevec(24'h300000, int'(i));
    return {4{24'h5A5A5A}};
  endfunction
  always_comb rd1_data = mem_read(rd1_kind, rd1_idx);
  always_comb rd2_data = mem_read(rd2_kind, rd2_idx);

  function automatic logic [95:0] fetch(int x);
    if (x < 0 || x > 127) return '0;
    if (x < 16) return filevec(24'h100000, x);
    if (x < 32) return filevec(24'h200000, x - 16);
    return filevec(24'h300000, x - 32);
  endfunction

  function automatic logic [95:0] swz(logic [95:0] v, logic [7:0] sel, bit neg);
    logic [95:0] r;
    for (int l = 0; l < 4; l++) r[24*l +: 24] = v[24*int'(sel[2*l +: 2]) +: 24] ^ {neg, 23'd0};
    return r;
  endfunction

  typedef struct {
    int stamp; bit valid; bit err;
    logic [95:0] op1, op2; logic [3:0] mask; logic [1:0] dk; logic [3:0] di;
    string tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(string tag, string what, logic [95:0] act, logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic issue(string tag, bit inv, bit [6:0] s1, bit [6:0] s2, bit [6:0] dst,
                       bit [1:0] asel, int a0, int a1, bit [3:0] mask,
                       bit [7:0] sel1, bit n1, bit [7:0] sel2, bit n2);
    exp_t e;
    int eff;
    @(negedge clk);
    in_valid = 1'b1; in_inverted = inv; in_src1 = s1; in_src2 = s2; in_dst = dst;
    in_asel = asel; in_areg0 = 8'(a0); in_areg1 = 8'(a1);
    in_desc = {n2, sel2, n1, sel1, mask};
    eff = int'(s1) + ((asel == 2'd1) ? a0 : (asel == 2'd2) ? a1 : 0);
    e.stamp = cyc; e.valid = !inv; e.err = inv; e.tag = tag;
    e.op1 = swz(fetch(eff), sel1, n1);
    e.op2 = swz(fetch(int'(s2)), sel2, n2);
    e.mask = mask;
    if (dst < 8) begin e.dk = 2'd1; e.di = 4'(dst); end
    else if (dst >= 16 && dst < 32) begin e.dk = 2'd2; e.di = 4'(dst - 16); end
    else begin e.dk = 2'd0; e.di = 4'd0; end
    q.push_back(e);
  endtask

  task automatic idle(int n);
    exp_t e;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_inverted = 1'b0;
      e = '{default: 0, tag: "R9"};
      e.stamp = cyc;
      q.push_back(e);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0 && q[0].stamp < cyc) begin
        e = q.pop_front();
        chk(e.err ? "R8" : "R9", "valid", 96'(out_valid), 96'(e.valid));
        chk(e.err ? "R8" : "R9", "err", 96'(out_err), 96'(e.err));
        if (e.valid) begin
          chk(e.tag, "op1", out_op1, e.op1);
          chk(e.tag, "op2", out_op2, e.op2);
          chk(e.tag, "mask", 96'(out_mask), 96'(e.mask));
          chk(e.tag, "dst_kind", 96'(out_dst_kind), 96'(e.dk));
          chk(e.tag, "dst_idx", 96'(out_dst_idx), 96'(e.di));
        end
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  localparam bit [7:0] ID = 8'hE4;
  initial begin : driver
    bit [31:0] lfsr;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reset valid", 96'(out_valid), 96'd0);
    chk("R9", "reset err", 96'(out_err), 96'd0);
    chk("R9", "reset op1", out_op1, 96'd0);
    chk("R9", "reset dst", 96'({out_mask, out_dst_kind, out_dst_idx}), 96'd0);
    rst_n = 1'b1;
    idle(2);
    // R1: file mapping
    issue("R1", 0, 7'h03, 7'h15, 7'h02, 2'd0, 0, 0, 4'hF, ID, 0, ID, 0);
    issue("R1", 0, 7'h20, 7'h7F, 7'h02, 2'd0, 0, 0, 4'hF, ID, 0, ID, 0);
    issue("R1", 0, 7'h0F, 7'h10, 7'h02, 2'd0, 0, 0, 4'hF, ID, 0, ID, 0);
    issue("R1", 0, 7'h1F, 7'h45, 7'h02, 2'd0, 0, 0, 4'hF, ID, 0, ID, 0);
    // R2: offset pushes the index out of range
    issue("R2", 0, 7'h7F, 7'h01, 7'h02, 2'd1, 1, 0, 4'hF, ID, 0, ID, 0);
    issue("R2", 0, 7'h02, 7'h01, 7'h02, 2'd2, 0, -5, 4'hF, ID, 1, ID, 0);
    // R3: offsets
    issue("R3", 0, 7'h1E, 7'h1E, 7'h02, 2'd1, 3, 50, 4'hF, ID, 0, ID, 0);
    issue("R3", 0, 7'h22, 7'h22, 7'h02, 2'd2, 9, -4, 4'hF, ID, 0, ID, 0);
    issue("R3", 0, 7'h05, 7'h05, 7'h02, 2'd0, 7, 7, 4'hF, ID, 0, ID, 0);
    issue("R3", 0, 7'h05, 7'h06, 7'h02, 2'd3, 7, 7, 4'hF, ID, 0, ID, 0);
    // R4: component selection
    issue("R4", 0, 7'h04, 7'h14, 7'h01, 2'd0, 0, 0, 4'hF, 8'h1B, 0, 8'h00, 0);
    issue("R4", 0, 7'h30, 7'h07, 7'h01, 2'd0, 0, 0, 4'hF, 8'hFF, 0, 8'h9C, 0);
    // R5: negation
    issue("R5", 0, 7'h04, 7'h14, 7'h01, 2'd0, 0, 0, 4'hF, ID, 1, ID, 0);
    issue("R5", 0, 7'h04, 7'h14, 7'h01, 2'd0, 0, 0, 4'hF, ID, 0, ID, 1);
    issue("R5", 0, 7'h50, 7'h0A, 7'h01, 2'd0, 0, 0, 4'hF, 8'h1B, 1, 8'h55, 1);
    // R6: write mask
    issue("R6", 0, 7'h01, 7'h01, 7'h01, 2'd0, 0, 0, 4'h0, ID, 0, ID, 0);
    issue("R6", 0, 7'h01, 7'h01, 7'h01, 2'd0, 0, 0, 4'h5, ID, 0, ID, 0);
    issue("R6", 0, 7'h01, 7'h01, 7'h01, 2'd0, 0, 0, 4'hA, ID, 0, ID, 0);
    // R7: destination decode
    for (int k = 0; k < 8; k++) begin
      bit [6:0] d;
      d = (k == 0) ? 7'h00 : (k == 1) ? 7'h07 : (k == 2) ? 7'h08 : (k == 3) ? 7'h0F :
          (k == 4) ? 7'h10 : (k == 5) ? 7'h1F : (k == 6) ? 7'h20 : 7'h7F;
      issue("R7", 0, 7'h02, 7'h03, d, 2'd0, 0, 0, 4'hF, ID, 0, ID, 0);
    end
    // R8: swapped roles
    issue("R8", 1, 7'h02, 7'h03, 7'h01, 2'd0, 0, 0, 4'hF, ID, 0, ID, 0);
    idle(1);
    issue("R8", 1, 7'h12, 7'h13, 7'h11, 2'd1, 2, 0, 4'hF, ID, 0, ID, 0);
    issue("R9", 0, 7'h12, 7'h13, 7'h11, 2'd0, 0, 0, 4'h3, ID, 0, ID, 0);
    idle(2);
    // mixed pattern sweep covering R1 to R7 jointly
    lfsr = 32'hACE1_1357;
    for (int n = 0; n < 300; n++) begin
      bit [31:0] r2;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      r2 = lfsr * 32'h9E37_79B9;
      issue("R4", 0, lfsr[6:0], lfsr[13:7], lfsr[20:14], lfsr[22:21],
            int'($signed(r2[7:0])), int'($signed(r2[15:8])), r2[19:16],
            r2[27:20], r2[28], {lfsr[27:23], r2[31:29]}, lfsr[31]);
      if (lfsr[4:0] == 5'd0) idle(1);
    end
    idle(3);
    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule